// File: doc/BRIEF.md
# Decimal and ASCII Adjust Unit

This unit takes a 16-bit accumulator, split into a high byte and a low byte, that holds the raw result of binary arithmetic. It corrects that value into decimal digit form. One 3-bit mode field selects the correction:

- packed add or packed subtract fix-up, with two digits per byte;
- unpacked add or unpacked subtract fix-up, with one digit per byte;
- a split of a binary byte into two unpacked digits, used after a multiply;
- a join of two unpacked digits into one binary byte, used before a divide.

The incoming carry and half-carry flags take part in the packed and unpacked fix-ups, and the unit returns updated values for both.

Operands arrive over a valid/ready stream and leave over another. Parameter `OUT_REG` chooses the output stage:

- When `OUT_REG` is 1, there is one output register. A result appears one cycle after it is accepted. The stage takes a new operand in the same cycle that its held result is consumed.
- When `OUT_REG` is 0, the unit is purely combinational from input to output, and `in_ready` follows `out_ready`.

Under back-pressure the upstream side must keep `in_valid` and its operand steady until `in_ready` is seen. The output side keeps `out_valid` and the result steady until `out_ready` is seen.

Top module: `bcd_adjust_unit`

## Requirements
- R1: Mode 0 (packed add). If the low nibble of the low byte is above 9, or the half-carry input is 1, 06h is added to the low byte and the half-carry output is 1; otherwise the half-carry output is 0. For example, 7Ch becomes 82h.
- R2: Modes 0 and 1. After the low fix-up, a 60h correction is applied if any of these hold: the upper nibble is above 9, the step carried or borrowed out of the byte, or the carry input is 1. The correction is added in mode 0 and subtracted in mode 1. The carry output equals whether this correction happened, so a carry input of 1 always gives a carry output of 1. For example, 9Ah becomes 00h with carry 1.
- R3: Mode 1 (packed subtract). The low fix-up uses the same condition as R1 but subtracts 06h. For example, 2Fh becomes 29h with half-carry 1. The high byte is unchanged in modes 0 and 1.
- R4: Mode 2 (unpacked add). If the low nibble is above 9, or the half-carry input is 1, the unit adds 06h to the low byte, adds 1 to the high byte, and sets both flags to 1. Otherwise both flags become 0. The upper nibble of the low byte is always cleared. For example, 0067h becomes 0007h and 053Bh becomes 0601h.
- R5: Mode 3 (unpacked subtract). This is the same as R4, except that it subtracts 06h from the low byte and 1 from the high byte. For example, 0233h with half-carry 1 becomes 010Dh.
- R6: Mode 4 (split). The high byte becomes the low byte divided by ten and the low byte becomes the remainder. For example, 0024h becomes 0306h. Both flags pass through unchanged.
- R7: Mode 5 (join). The low byte becomes (high byte × 10 + low byte) mod 256 and the high byte becomes 0. For example, 0508h becomes 003Ah. Both flags pass through unchanged.
- R8: Modes 6 and 7 pass the accumulator and both flags through unchanged.
- R9: With `OUT_REG`=1:
  - a result is presented one cycle after the handshake that accepted it;
  - while `out_valid` is 1 and `out_ready` is 0, the output fields and `out_valid` hold steady;
  - `in_ready` is 1 whenever the stage is empty or `out_ready` is 1;
  - results leave in arrival order.
- R10: While reset is low (active-low `rst_n`), `out_valid` is 0 and `in_ready` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Operand present |
| in_ready | output | 1 | Unit can take an operand this cycle |
| in_acc | input | 16 | Accumulator: [15:8] high byte, [7:0] low byte |
| in_cf | input | 1 | Carry flag in |
| in_af | input | 1 | Half-carry flag in |
| in_op | input | 3 | Mode: 0 packed add, 1 packed sub, 2 unpacked add, 3 unpacked sub, 4 split, 5 join, 6-7 pass |
| out_valid | output | 1 | Result present |
| out_ready | input | 1 | Consumer takes the result this cycle |
| out_acc | output | 16 | Corrected accumulator |
| out_cf | output | 1 | Carry flag out |
| out_af | output | 1 | Half-carry flag out |

## Verification
Two events can land on the same clock edge: the draining of a held result and the capture of the next operand. This happens when `out_valid`, `out_ready` and `in_valid` are all high together. The bench drives long bursts of back-to-back operands while it raises and drops `out_ready` on a pseudo-random pattern, so both overlap cycles and stall cycles occur often. Every consumed result is compared in order against a queue filled by a behavioural model. Any cycle after a stall must show an unchanged output, which shows that a capture during a drain neither loses nor duplicates an operand.

// File: rtl/adj_pkg.sv
package adj_pkg;
  localparam int BYTE_W = 8;
  localparam int NIB_W  = 4;
  localparam int ACC_W  = 2 * BYTE_W;
  localparam int OP_W   = 3;
  localparam logic [NIB_W-1:0]  DIGIT_MAX = 4'd9;
  localparam logic [BYTE_W-1:0] FIX_LO    = 8'h06;
  localparam logic [BYTE_W-1:0] FIX_HI    = 8'h60;
  localparam logic [BYTE_W-1:0] RADIX     = 8'd10;

  typedef enum logic [OP_W-1:0] {
    OP_PK_ADD  = 3'd0,
    OP_PK_SUB  = 3'd1,
    OP_UN_ADD  = 3'd2,
    OP_UN_SUB  = 3'd3,
    OP_SPLIT   = 3'd4,
    OP_JOIN    = 3'd5
  } adj_op_e;
endpackage

// File: rtl/bcd_packed_fix.sv
module bcd_packed_fix
  import adj_pkg::*;
(
  input  logic              sub,
  input  logic [BYTE_W-1:0] al,
  input  logic              cf,
  input  logic              af,
  output logic [BYTE_W-1:0] al_o,
  output logic              cf_o,
  output logic              af_o
);
  logic              lo_fix;
  logic              hi_fix;
  logic [BYTE_W:0]   step1;

  always_comb begin
    lo_fix = (al[NIB_W-1:0] > DIGIT_MAX) | af;
    if (sub) step1 = {1'b0, al} - {1'b0, (lo_fix ? FIX_LO : '0)};
    else     step1 = {1'b0, al} + {1'b0, (lo_fix ? FIX_LO : '0)};
    // step1[BYTE_W] is the carry or borrow out of the low correction
    hi_fix = cf | step1[BYTE_W] | (step1[BYTE_W-1:NIB_W] > DIGIT_MAX);
    if (sub) al_o = step1[BYTE_W-1:0] - (hi_fix ? FIX_HI : '0);
    else     al_o = step1[BYTE_W-1:0] + (hi_fix ? FIX_HI : '0);
    cf_o = hi_fix;
    af_o = lo_fix;
  end

  always_comb begin
    if (!$isunknown({al, cf, af, al_o, cf_o})) begin
      // R2
      cf_sticky_chk: assert (!cf || cf_o);
      // R1
      bcd_pass_chk: assert (cf || af || al[7:4] > DIGIT_MAX || al[3:0] > DIGIT_MAX
                            || (al_o == al && !cf_o));
    end
  end
endmodule

// File: rtl/bcd_unpacked_fix.sv
module bcd_unpacked_fix
  import adj_pkg::*;
(
  input  logic              sub,
  input  logic [BYTE_W-1:0] ah,
  input  logic [BYTE_W-1:0] al,
  input  logic              af,
  output logic [BYTE_W-1:0] ah_o,
  output logic [BYTE_W-1:0] al_o,
  output logic              flag_o
);
  logic             fix;
  logic [NIB_W-1:0] digit;

  always_comb begin
    fix = (al[NIB_W-1:0] > DIGIT_MAX) | af;
    if (!fix)     digit = al[NIB_W-1:0];
    else if (sub) digit = al[NIB_W-1:0] - FIX_LO[NIB_W-1:0];
    else          digit = al[NIB_W-1:0] + FIX_LO[NIB_W-1:0];
    al_o = {{(BYTE_W-NIB_W){1'b0}}, digit};
    if (!fix)     ah_o = ah;
    else if (sub) ah_o = ah - 8'd1;
    else          ah_o = ah + 8'd1;
    flag_o = fix;
  end

  always_comb begin
    if (!$isunknown({ah, al, af, ah_o, flag_o})) begin
      // R4
      carry_step_chk: assert (flag_o ? (ah_o != ah) : (ah_o == ah));
      // R4
      plain_digit_chk: assert (af || al[3:0] > DIGIT_MAX || al_o == {4'h0, al[3:0]});
    end
  end
endmodule

// File: rtl/bcd_radix_conv.sv
module bcd_radix_conv
  import adj_pkg::*;
(
  input  logic              join_mode,
  input  logic [BYTE_W-1:0] ah,
  input  logic [BYTE_W-1:0] al,
  output logic [BYTE_W-1:0] ah_o,
  output logic [BYTE_W-1:0] al_o
);
  logic [BYTE_W-1:0] tens;
  logic [BYTE_W-1:0] units;
  logic [BYTE_W-1:0] joined;

  always_comb begin
    tens   = al / RADIX;
    units  = al % RADIX;
    joined = (ah << 3) + (ah << 1) + al;
    if (join_mode) begin
      ah_o = '0;
      al_o = joined;
    end else begin
      ah_o = tens;
      al_o = units;
    end
  end

  always_comb begin
    if (!$isunknown({join_mode, al, ah_o, al_o}) && !join_mode) begin
      // R6
      split_rebuild_chk: assert ((16'(ah_o) * 16'd10 + 16'(al_o)) == 16'(al) && al_o < RADIX);
    end
  end
endmodule

// File: rtl/bcd_adjust_unit.sv
module bcd_adjust_unit
  import adj_pkg::*;
#(
  parameter bit OUT_REG = 1'b1
)(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             in_valid,
  output logic             in_ready,
  input  logic [ACC_W-1:0] in_acc,
  input  logic             in_cf,
  input  logic             in_af,
  input  logic [OP_W-1:0]  in_op,
  output logic             out_valid,
  input  logic             out_ready,
  output logic [ACC_W-1:0] out_acc,
  output logic             out_cf,
  output logic             out_af
);
  adj_op_e           op;
  logic [BYTE_W-1:0] ah, al;
  logic [BYTE_W-1:0] pk_al;
  logic              pk_cf, pk_af;
  logic [BYTE_W-1:0] un_ah, un_al;
  logic              un_flag;
  logic [BYTE_W-1:0] rc_ah, rc_al;
  logic [ACC_W-1:0]  res_acc;
  logic              res_cf, res_af;

  assign op = adj_op_e'(in_op);
  assign ah = in_acc[ACC_W-1:BYTE_W];
  assign al = in_acc[BYTE_W-1:0];

  bcd_packed_fix u_packed (
    .sub(in_op == OP_PK_SUB), .al(al), .cf(in_cf), .af(in_af),
    .al_o(pk_al), .cf_o(pk_cf), .af_o(pk_af)
  );

  bcd_unpacked_fix u_unpacked (
    .sub(in_op == OP_UN_SUB), .ah(ah), .al(al), .af(in_af),
    .ah_o(un_ah), .al_o(un_al), .flag_o(un_flag)
  );

  bcd_radix_conv u_radix (
    .join_mode(in_op == OP_JOIN), .ah(ah), .al(al),
    .ah_o(rc_ah), .al_o(rc_al)
  );

  always_comb begin
    res_acc = in_acc;
    res_cf  = in_cf;
    res_af  = in_af;
    case (op)
      OP_PK_ADD, OP_PK_SUB: begin
        res_acc = {ah, pk_al};
        res_cf  = pk_cf;
        res_af  = pk_af;
      end
      OP_UN_ADD, OP_UN_SUB: begin
        res_acc = {un_ah, un_al};
        res_cf  = un_flag;
        res_af  = un_flag;
      end
      OP_SPLIT, OP_JOIN: res_acc = {rc_ah, rc_al};
      default: ;
    endcase
  end

  generate
    if (OUT_REG) begin : g_reg
      logic             v_q;
      logic [ACC_W-1:0] acc_q;
      logic             cf_q, af_q;

      assign in_ready = !v_q || out_ready;

      always_ff @(posedge clk) begin
        if (!rst_n) begin
          v_q   <= 1'b0;
          acc_q <= '0;
          cf_q  <= 1'b0;
          af_q  <= 1'b0;
        end else if (in_ready) begin
          v_q <= in_valid;
          if (in_valid) begin
            acc_q <= res_acc;
            cf_q  <= res_cf;
            af_q  <= res_af;
          end
        end
      end

      assign out_valid = v_q;
      assign out_acc   = acc_q;
      assign out_cf    = cf_q;
      assign out_af    = af_q;

      // R9
      hold_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid && !out_ready |=> out_valid && $stable(out_acc) && $stable(out_cf) && $stable(out_af));
      // R9
      accept_present_chk: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid && in_ready |=> out_valid);
      // R9
      empty_ready_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !out_valid |-> in_ready);
    end else begin : g_thru
      assign in_ready  = out_ready;
      assign out_valid = in_valid;
      assign out_acc   = res_acc;
      assign out_cf    = res_cf;
      assign out_af    = res_af;
    end
  endgenerate

  // R8
  pass_mode_chk: assert property (@(posedge clk) disable iff (!rst_n)
    OUT_REG && in_valid && in_ready && in_op[2:1] == 2'b11
    |=> out_acc == $past(in_acc) && out_cf == $past(in_cf) && out_af == $past(in_af));
endmodule

// File: tb/bcd_adjust_unit_tb.sv
`timescale 1ns/1ps
module bcd_adjust_unit_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        in_valid = 1'b0;
  logic        in_ready;
  logic [15:0] in_acc = '0;
  logic        in_cf = 1'b0, in_af = 1'b0;
  logic [2:0]  in_op = '0;
  logic        out_valid;
  logic        out_ready = 1'b0;
  logic [15:0] out_acc;
  logic        out_cf, out_af;

  int checks = 0, failures = 0;
  bit done = 0;
  int stall_pct = 0;

  logic [17:0] exp_q[$];
  string       tag_q[$];

  always #2.5 clk = ~clk;

  bcd_adjust_unit #(.OUT_REG(1'b1)) dut_i (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_acc(in_acc), .in_cf(in_cf), .in_af(in_af), .in_op(in_op),
    .out_valid(out_valid), .out_ready(out_ready), .out_acc(out_acc),
    .out_cf(out_cf), .out_af(out_af)
  );

  function automatic logic [17:0] model(int op, int acc, bit cf, bit af);
    int hi = (acc >> 8) & 255;
    int lo = acc & 255;
    int t;
    bit lf, hf;
    case (op)
      0, 1: begin
        lf = ((lo % 16) > 9) || af;
        t  = (op == 0) ? lo + (lf ? 6 : 0) : lo - (lf ? 6 : 0);
        hf = cf || t > 255 || t < 0 || (((t & 255) / 16) > 9);
        t  = (op == 0) ? t + (hf ? 96 : 0) : t - (hf ? 96 : 0);
        return {8'(hi), 8'(t & 255), hf, lf};
      end
      2, 3: begin
        lf = ((lo % 16) > 9) || af;
        if (lf) begin
          t  = (op == 2) ? lo + 6 : lo - 6;
          hi = (op == 2) ? hi + 1 : hi - 1;
        end else t = lo;
        return {8'(hi & 255), 8'(t & 15), lf, lf};
      end
      4: return {8'(lo / 10), 8'(lo % 10), cf, af};
      5: return {8'h00, 8'((hi * 10 + lo) & 255), cf, af};
      default: return {16'(acc), cf, af};
    endcase
  endfunction

  function automatic string op_tag(int op);
    case (op)
      0: return "R1";  1: return "R3";  2: return "R4";
      3: return "R5";  4: return "R6";  5: return "R7";
      default: return "R8";
    endcase
  endfunction

  task automatic pick_ready();
    out_ready = ($urandom % 100) >= stall_pct;
  endtask

  task automatic send(int op, int acc, bit cf, bit af, string tag);
    @(negedge clk);
    in_valid = 1'b1; in_op = 3'(op); in_acc = 16'(acc); in_cf = cf; in_af = af;
    pick_ready();
    #1;
    while (!in_ready) begin
      @(negedge clk);
      pick_ready();
      #1;
    end
    exp_q.push_back(model(op, acc, cf, af));
    tag_q.push_back(tag);
  endtask

  // Monitor: compare every consumed result and stall hold (R9)
  logic        prev_stall = 1'b0;
  logic [17:0] prev_out;
  always @(negedge clk) begin
    #2;
    if (rst_n && !done) begin
      if (prev_stall) begin
        checks++;
        if (!out_valid || {out_acc, out_cf, out_af} != prev_out) begin
          failures++;
          $display("FAIL R9 hold: got v=%0b %h expected v=1 %h", out_valid,
                   {out_acc, out_cf, out_af}, prev_out);
        end
      end
      if (out_valid && out_ready) begin
        checks++;
        if (exp_q.size() == 0) begin
          failures++;
          $display("FAIL R9 order: got %h expected no result", {out_acc, out_cf, out_af});
        end else begin
          logic [17:0] e;
          string tg;
          e = exp_q.pop_front();
          tg = tag_q.pop_front();
          if ({out_acc, out_cf, out_af} !== e) begin
            failures++;
            $display("FAIL %s: got acc=%h cf=%0b af=%0b expected acc=%h cf=%0b af=%0b",
                     tg, out_acc, out_cf, out_af, e[17:2], e[1], e[0]);
          end
        end
      end
      prev_stall = out_valid && !out_ready;
      prev_out   = {out_acc, out_cf, out_af};
    end
  end

  task automatic finish_run();
    done = 1;
    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  endtask

  initial begin
    #(5.0 * 100000);
    if (!done) begin
      checks++; failures++;
      $display("FAIL R9 watchdog: got hang expected completion");
      finish_run();
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    #1;
    checks++;
    // R10 reset state
    if (out_valid !== 1'b0 || in_ready !== 1'b1) begin
      failures++;
      $display("FAIL R10: got out_valid=%0b in_ready=%0b expected 0 1", out_valid, in_ready);
    end
    @(negedge clk); rst_n = 1'b1;

    stall_pct = 0;
    send(0, 16'h007C, 0, 0, "R1");
    send(0, 16'h1145, 0, 1, "R1");
    send(0, 16'h009A, 0, 0, "R2");
    send(0, 16'h0012, 1, 0, "R2");
    send(1, 16'h002F, 0, 0, "R3");
    send(1, 16'h0010, 1, 0, "R2");
    send(1, 16'h0003, 0, 1, "R3");
    send(2, 16'h0067, 0, 0, "R4");
    send(2, 16'h053B, 0, 0, "R4");
    send(2, 16'hFF12, 0, 1, "R4");
    send(3, 16'h0233, 0, 1, "R5");
    send(3, 16'h0039, 1, 0, "R5");
    send(4, 16'h0024, 1, 0, "R6");
    send(4, 16'h00FF, 0, 1, "R6");
    send(5, 16'h0508, 0, 0, "R7");
    send(5, 16'h0909, 1, 1, "R7");
    send(6, 16'hABCD, 1, 0, "R8");
    send(7, 16'h1234, 0, 1, "R8");

    // back-pressure with drain and capture in the same cycle (R9)
    stall_pct = 40;
    for (int i = 0; i < 400; i++) begin
      int op = $urandom % 8;
      send(op, $urandom % 65536, 1'($urandom), 1'($urandom), op_tag(op));
    end

    @(negedge clk);
    in_valid = 1'b0;
    for (int i = 0; i < 50 && exp_q.size() != 0; i++) begin
      out_ready = (i % 3) != 1;
      @(negedge clk);
    end
    out_ready = 1'b1;
    repeat (3) @(negedge clk);
    #3;
    checks++;
    if (exp_q.size() != 0 || out_valid) begin
      failures++;
      $display("FAIL R9 drain: got pending=%0d valid=%0b expected 0 0", exp_q.size(), out_valid);
    end
    finish_run();
  end
endmodule